// File: doc/BRIEF.md
# Long-Wire Turnaround Delay Controller

This block manages the reversal of a connection at ports whose links run over pipelined long wires. Each such wire adds whole clock cycles of register delay. When a port sees the turn indication, its engine works out how many cycles must pass before reverse data can be trusted. That count is two cycles plus two for each configured wire-delay cycle: one cycle for the turn to travel out and one for the data to come back. Until then the engine drives filler on its reverse-stream output. The filler is the status byte and the checksum byte, captured when the turn arrives and repeated in alternation, so the component on the short-wire side always receives defined words. After the gap, the engine forwards reverse data until the connection is dropped.

There are sixteen independent engines, one per port. The wire delay of every port is a 3-bit field held in a single serial configuration chain. The chain is shifted in one bit per cycle while the program enable is high. An engine reads its field only when it accepts a turn, so reprogramming never disturbs a turnaround already in progress.

The reverse stream is valid-only and has no ready. The long-wire pipeline cannot stall, so there is no back-pressure: a word presented with its valid flag high in a forwarding cycle always appears on the output one cycle later. The fill flag marks filler words, and filler words never carry the valid flag.

Top module: `tad_turnaround_ctrl`

## Requirements
- R1: After reset, every port's reverse-stream output is zero with valid and fill low, and every configured delay is 0.
- R2: While `prog_en` is high, the chain shifts left by one bit per cycle, taking `prog_din` into bit 0. Port p's delay is chain bits [3p+2:3p]. A 48-bit load is sent MSB-first, so the first bit sent ends in bit 2 of port 15's field.
- R3: While `prog_en` is low, the chain holds its contents whatever `prog_din` does.
- R4: A turn is accepted in the idle state at the clock edge that samples `turn_i` high (edge 0). With D the port's delay field, L = 2 + 2·D. Edge L+1 is the first edge at which reverse input is taken.
- R5: On edges 1 to L after the turn, the port outputs fill high and valid low. The data is the status byte sampled at edge 0 on odd edges and the checksum byte sampled at edge 0 on even edges.
- R6: Reverse input presented before edge L+1, with its valid flag high or low, never raises the output valid flag and never appears on the output.
- R7: From edge L+1 on, each edge registers `rev_valid_i` and `rev_data_i` onto `out_valid_o` and `out_data_o`, with fill low.
- R8: `drop_i` high at an edge returns the port to idle, with outputs zeroed after that edge, in any state. If `drop_i` and `turn_i` are high at the same edge, the drop wins.
- R9: A turn is ignored while `prog_en` is high and while the port is not idle.
- R10: The delay used by a turnaround is the field value at edge 0. Changes to the chain take effect at the next accepted turn.
- R11: Ports operate independently. A turnaround on one port leaves the outputs of idle ports at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_en | input | 1 | Configuration shift enable |
| prog_din | input | 1 | Serial configuration bit |
| turn_i | input | 16 | Per-port turn indication |
| drop_i | input | 16 | Per-port connection drop |
| status_i | input | 128 | Per-port status byte (port p at [8p+7:8p]) |
| cksum_i | input | 128 | Per-port checksum byte |
| rev_valid_i | input | 16 | Per-port reverse data valid |
| rev_data_i | input | 128 | Per-port reverse data |
| out_data_o | output | 128 | Per-port reverse-stream word |
| out_valid_o | output | 16 | Per-port reverse data valid flag |
| out_fill_o | output | 16 | Per-port filler-word flag |

## Verification
Turnarounds are run with delay 0 straight out of reset, and then with delays 2, 3, 5 and 7 after programming. A wrong multiplier or offset in the latency shows up as the first valid word landing on a different edge. Reverse valid is held high through every gap, which separates real gating from a design that merely forwards late. The status and checksum inputs are inverted right after the turn, which separates capture from pass-through. A bubble, a second turn while forwarding, drops during the gap and together with a turn, and a reprogramming that overlaps a long turnaround cover the remaining orderings.

// File: rtl/tad_pkg.sv
package tad_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GAP  = 2'd1,
    ST_FWD  = 2'd2
  } tad_state_e;
endpackage

// File: rtl/tad_cfg_chain.sv
module tad_cfg_chain #(
  parameter int N_PORTS = 16,
  parameter int DW      = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    prog_en,
  input  logic                    prog_din,
  output logic [N_PORTS*DW-1:0]   chain_o
);
  localparam int CHAIN_W = N_PORTS * DW;

  logic [CHAIN_W-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else if (prog_en) begin
      chain_q <= {chain_q[CHAIN_W-2:0], prog_din};
    end
  end

  assign chain_o = chain_q;

  // R2: a shift takes the serial bit into the lowest position
  p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
    prog_en |=> chain_q[0] == $past(prog_din));

  // R3: contents hold without the enable
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_en |=> $stable(chain_q));
endmodule

// File: rtl/tad_port_engine.sv
module tad_port_engine
  import tad_pkg::*;
#(
  parameter int W  = 8,
  parameter int DW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_en,
  input  logic          turn,
  input  logic          drop,
  input  logic [DW-1:0] cfg_delay,
  input  logic [W-1:0]  status,
  input  logic [W-1:0]  cksum,
  input  logic          rev_valid,
  input  logic [W-1:0]  rev_data,
  output logic [W-1:0]  out_data,
  output logic          out_valid,
  output logic          out_fill
);
  localparam int LAT_MAX = 2 + 2 * ((1 << DW) - 1);
  localparam int CW      = $clog2(LAT_MAX + 1);

  tad_state_e      state;
  logic [CW-1:0]   cnt;
  logic [CW-1:0]   lat;
  logic [W-1:0]    st_q;
  logic [W-1:0]    ck_q;
  logic            gap_done;
  logic [W-1:0]    fill_word;

  assign gap_done  = (cnt == lat);
  assign fill_word = cnt[0] ? ck_q : st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      lat       <= CW'(2);
      st_q      <= '0;
      ck_q      <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
      out_fill  <= 1'b0;
    end else if (drop) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
      out_fill  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (turn && !prog_en) begin
            state <= ST_GAP;
            cnt   <= '0;
            lat   <= CW'(2) + (CW'(cfg_delay) << 1);
            st_q  <= status;
            ck_q  <= cksum;
          end
        end
        ST_GAP: begin
          if (gap_done) begin
            state     <= ST_FWD;
            out_valid <= rev_valid;
            out_data  <= rev_data;
            out_fill  <= 1'b0;
          end else begin
            out_valid <= 1'b0;
            out_fill  <= 1'b1;
            out_data  <= fill_word;
            cnt       <= cnt + CW'(1);
          end
        end
        ST_FWD: begin
          out_valid <= rev_valid;
          out_data  <= rev_data;
          out_fill  <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5: a filler word never carries the valid flag
  p_fill_not_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_fill |-> !out_valid);

  // R4: the gap counter never passes the latched latency
  p_gap_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GAP) |-> (cnt <= lat));

  // R6: valid rises only from the end of the gap or while forwarding
  p_first_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> ($past(state == ST_GAP && cnt == lat) || $past(state == ST_FWD)));

  // R8: a drop clears the stream flags
  p_drop_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> (!out_valid && !out_fill && state == ST_IDLE));

  // R9: no turn is taken while programming
  p_prog_blocks_turn_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && prog_en) |=> (state == ST_IDLE));

  // R10: latency stays fixed for the whole turnaround
  p_lat_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(lat));
endmodule

// File: rtl/tad_turnaround_ctrl.sv
module tad_turnaround_ctrl #(
  parameter int N_PORTS = 16,
  parameter int W       = 8,
  parameter int DW      = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   prog_en,
  input  logic                   prog_din,
  input  logic [N_PORTS-1:0]     turn_i,
  input  logic [N_PORTS-1:0]     drop_i,
  input  logic [N_PORTS*W-1:0]   status_i,
  input  logic [N_PORTS*W-1:0]   cksum_i,
  input  logic [N_PORTS-1:0]     rev_valid_i,
  input  logic [N_PORTS*W-1:0]   rev_data_i,
  output logic [N_PORTS*W-1:0]   out_data_o,
  output logic [N_PORTS-1:0]     out_valid_o,
  output logic [N_PORTS-1:0]     out_fill_o
);
  localparam int CHAIN_W = N_PORTS * DW;

  logic [CHAIN_W-1:0] chain;

  tad_cfg_chain #(.N_PORTS(N_PORTS), .DW(DW)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .prog_en  (prog_en),
    .prog_din (prog_din),
    .chain_o  (chain)
  );

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    tad_port_engine #(.W(W), .DW(DW)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .prog_en   (prog_en),
      .turn      (turn_i[p]),
      .drop      (drop_i[p]),
      .cfg_delay (chain[p*DW +: DW]),
      .status    (status_i[p*W +: W]),
      .cksum     (cksum_i[p*W +: W]),
      .rev_valid (rev_valid_i[p]),
      .rev_data  (rev_data_i[p*W +: W]),
      .out_data  (out_data_o[p*W +: W]),
      .out_valid (out_valid_o[p]),
      .out_fill  (out_fill_o[p])
    );
  end
endmodule

// File: tb/tad_turnaround_ctrl_test.sv
module tad_turnaround_ctrl_test;
  localparam int N = 16;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           prog_en = 1'b0;
  logic           prog_din = 1'b0;
  logic [N-1:0]   turn_i = '0;
  logic [N-1:0]   drop_i = '0;
  logic [N*W-1:0] status_i = '0;
  logic [N*W-1:0] cksum_i = '0;
  logic [N-1:0]   rev_valid_i = '0;
  logic [N*W-1:0] rev_data_i = '0;
  logic [N*W-1:0] out_data_o;
  logic [N-1:0]   out_valid_o;
  logic [N-1:0]   out_fill_o;

  tad_turnaround_ctrl uut (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .prog_din(prog_din),
    .turn_i(turn_i), .drop_i(drop_i), .status_i(status_i), .cksum_i(cksum_i),
    .rev_valid_i(rev_valid_i), .rev_data_i(rev_data_i),
    .out_data_o(out_data_o), .out_valid_o(out_valid_o), .out_fill_o(out_fill_o)
  );

  always #2 clk = ~clk;

  typedef struct {
    int       cyc;
    int       port;
    logic     v;
    logic     f;
    logic [7:0] d;
    string    req;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   nvec = 0;
  int   nfail = 0;
  bit   done = 0;
  int   dl[16];
  int   nd[16];

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare every expectation due at this cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      logic [7:0] ad;
      e  = q.pop_front();
      ad = out_data_o[e.port*W +: W];
      nvec++;
      if (e.cyc != cyc || out_valid_o[e.port] !== e.v || out_fill_o[e.port] !== e.f || ad !== e.d) begin
        nfail++;
        $display("FAIL %s port %0d cyc %0d: got v=%b f=%b d=%h, expected v=%b f=%b d=%h",
                 e.req, e.port, e.cyc, out_valid_o[e.port], out_fill_o[e.port], ad, e.v, e.f, e.d);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_at(int p, logic v, logic f, logic [7:0] d, string req);
    exp_t e;
    e.cyc = cyc + 1; e.port = p; e.v = v; e.f = f; e.d = d; e.req = req;
    q.push_back(e);
  endtask

  // R2: MSB-first load, port 15 field first
  task automatic program_delays(int vals[16]);
    prog_en = 1'b1;
    for (int p = N - 1; p >= 0; p--) begin
      for (int b = 2; b >= 0; b--) begin
        prog_din = vals[p][b];
        tick();
      end
    end
    prog_en = 1'b0;
    prog_din = 1'b0;
  endtask

  task automatic turn_seq(int p, int d, logic [7:0] st, logic [7:0] ck, int drop_at, int nfwd);
    int L;
    int o;
    L = 2 + 2 * d;
    o = (p + 8) % N;
    turn_i[p] = 1'b1;
    status_i[p*W +: W] = st;
    cksum_i[p*W +: W]  = ck;
    expect_at(p, 1'b0, 1'b0, 8'h00, "R4");
    tick();
    turn_i[p] = 1'b0;
    status_i[p*W +: W] = ~st;   // R5: capture, not pass-through
    cksum_i[p*W +: W]  = ~ck;
    for (int k = 1; k <= L + nfwd; k++) begin
      if (k == drop_at) begin
        drop_i[p] = 1'b1;
        rev_valid_i[p] = 1'b0;
        expect_at(p, 1'b0, 1'b0, 8'h00, "R8");
        tick();
        drop_i[p] = 1'b0;
        return;
      end
      if (k <= L) begin
        rev_valid_i[p] = 1'b1;               // R6: early data ignored
        rev_data_i[p*W +: W] = 8'hE0 + 8'(k);
        expect_at(p, 1'b0, 1'b1, (k % 2 == 1) ? st : ck, "R5_R6");
      end else begin
        int j;
        logic vv;
        logic [7:0] dd;
        j  = k - L;
        vv = (j != 2);
        dd = 8'h40 + 8'(k);
        rev_valid_i[p] = vv;
        rev_data_i[p*W +: W] = dd;
        if (j == 3) turn_i[p] = 1'b1;        // R9: turn while forwarding
        expect_at(p, vv, 1'b0, dd, (j == 1) ? "R4" : ((j == 3) ? "R9" : "R7"));
      end
      expect_at(o, 1'b0, 1'b0, 8'h00, "R11");
      tick();
      turn_i[p] = 1'b0;
    end
    drop_i[p] = 1'b1;
    rev_valid_i[p] = 1'b0;
    expect_at(p, 1'b0, 1'b0, 8'h00, "R8");
    tick();
    drop_i[p] = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) tick();
    rst_n = 1'b1;
    // R1: reset state
    expect_at(0, 1'b0, 1'b0, 8'h00, "R1");
    expect_at(7, 1'b0, 1'b0, 8'h00, "R1");
    expect_at(15, 1'b0, 1'b0, 8'h00, "R1");
    tick();

    // R1, R4: unprogrammed delay 0 gives L = 2
    turn_seq(0, 0, 8'hA5, 8'h3C, 0, 4);

    for (int p = 0; p < N; p++) dl[p] = p % 8;
    dl[3] = 7;
    program_delays(dl);

    // R3: toggling serial input without enable changes nothing
    for (int i = 0; i < 10; i++) begin
      prog_din = i[0];
      tick();
    end

    turn_seq(2, dl[2], 8'h11, 8'h22, 0, 4);
    turn_seq(7, dl[7], 8'h5A, 8'hC3, 0, 5);
    turn_seq(5, dl[5], 8'h77, 8'h88, 4, 0);   // R8: drop in the gap

    // R8: drop wins over a simultaneous turn
    turn_i[1] = 1'b1;
    drop_i[1] = 1'b1;
    expect_at(1, 1'b0, 1'b0, 8'h00, "R8");
    tick();
    turn_i[1] = 1'b0;
    drop_i[1] = 1'b0;
    expect_at(1, 1'b0, 1'b0, 8'h00, "R8");
    tick();

    for (int p = 0; p < N; p++) nd[p] = (p * 3 + 1) % 8;
    nd[3] = 1;
    fork
      turn_seq(3, dl[3], 8'h9C, 8'h61, 0, 4);   // R10: keeps delay 7
      begin
        tick();
        tick();
        program_delays(nd);
      end
      begin
        repeat (8) tick();
        turn_i[5] = 1'b1;                        // R9: ignored while programming
        expect_at(5, 1'b0, 1'b0, 8'h00, "R9");
        tick();
        turn_i[5] = 1'b0;
        for (int i = 0; i < 3; i++) begin
          expect_at(5, 1'b0, 1'b0, 8'h00, "R9");
          tick();
        end
      end
    join

    // R10: new delay used at the next accepted turn
    turn_seq(3, nd[3], 8'h0F, 8'hF0, 0, 3);
    turn_seq(6, nd[6], 8'h12, 8'h34, 0, 3);

    tick();
    tick();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule